// File: doc/BRIEF.md
# RMII Receive Byte Assembler with Link Speed Detection

This block is the receive front end for one RMII PHY. It runs on the 50 MHz reference clock and takes the PHY's 2-bit receive data together with its data-valid and error signals. It looks for the start of a frame in the preamble, works out from the length of that preamble whether the link runs at 100 Mbit/s or 10 Mbit/s, and then packs the frame's dibits into bytes.

Each byte leaves as a 9-bit word with a one-clock valid strobe. Bit 8 marks the first byte of a frame. A 2-bit speed code reports the rate found at the last lock, so that a transmit path can follow it. Preamble and delimiter bytes are consumed here and never reach the output. A frame with a broken preamble, an error indication or an early loss of data-valid is cut off cleanly, and the block then waits for the next preamble.

Top module: `rmii_rx_assembler`

## Requirements
- R1: After reset, rx_byte_valid is low and link_speed is 1 (100 Mbit/s).
- R2: Dibits form bytes least-significant pair first: the first dibit sampled in a byte becomes bits [1:0] and the fourth becomes bits [7:6].
- R3: Lock at 100 Mbit/s happens when exactly 31 consecutive valid samples of dibit 01 are followed by a sample of dibit 11. That is seven 0x55 bytes plus the low three dibits of the 0xD5 delimiter. link_speed becomes 1, and every following clock supplies one data dibit.
- R4: Lock at 10 Mbit/s happens when exactly 310 consecutive samples of 01 are followed by a sample of 11. link_speed becomes 0, and data dibits are taken only on clocks 10, 20, 30 and so on after the clock of that first 11 sample.
- R5: The first byte of a frame has bit 8 set. Every later byte of that frame has bit 8 clear.
- R6: Preamble and delimiter bytes are never emitted. rx_byte_valid is a single-clock strobe that rises only for data bytes, one clock after the edge that samples their fourth dibit.
- R7: A clock with rx_dv low ends any frame and returns the block to preamble hunt. A partly assembled byte is discarded.
- R8: A clock with rx_dv and rx_err both high aborts the frame or the hunt. No further byte is emitted until rx_dv has gone low and a new preamble locks.
- R9: If dibit 11 follows a run length other than 31 or 310, the frame is ignored until rx_dv goes low. A valid sample of 00 or 10 during hunt restarts the run count.
- R10: link_speed takes only the values 0 and 1. It changes only on a lock and holds its value between frames.
- R11: Two strobes of rx_byte_valid are at least 4 clocks apart at 100 Mbit/s and at least 40 clocks apart at 10 Mbit/s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz RMII reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_dibit | input | 2 | Receive data from the PHY |
| rx_dv | input | 1 | Receive data valid from the PHY |
| rx_err | input | 1 | Receive error from the PHY |
| rx_byte | output | 9 | Assembled byte; bit 8 marks the first byte of a frame |
| rx_byte_valid | output | 1 | One-clock strobe for rx_byte |
| link_speed | output | 2 | Detected speed: 1 = 100 Mbit/s, 0 = 10 Mbit/s (2 is reserved for gigabit) |

## Verification
The assertions assume the PHY holds each dibit for a whole number of sample periods. They also assume data-valid stays high from the first preamble dibit to the last data dibit, so a new lock can only follow a stretch with rx_dv low. The stimulus always builds frames whole: each dibit is repeated once or ten times, the frame is framed by rx_dv, and errors and truncations are placed on dibit boundaries. Runs that are too short or too long come only from the count of preamble bytes and never from partial dibits.

// File: rtl/rxa_pkg.sv
package rxa_pkg;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_DATA = 2'd1,
    ST_DEAD = 2'd2
  } rxa_state_e;

  localparam logic [1:0] DIBIT_PRE   = 2'b01;
  localparam logic [1:0] DIBIT_SFD   = 2'b11;
  localparam logic [1:0] SPEED_10M   = 2'd0;
  localparam logic [1:0] SPEED_100M  = 2'd1;
  localparam logic [1:0] SPEED_1000M = 2'd2;
  localparam int DIBITS_PER_BYTE = 4;

  // Number of 01 dibits seen before the first 11 dibit at one sample per dibit.
  function automatic int unsigned fast_run_len(input int unsigned pre_bytes);
    return pre_bytes * DIBITS_PER_BYTE + (DIBITS_PER_BYTE - 1);
  endfunction

  // The same run when every dibit is repeated `decim` times.
  function automatic int unsigned slow_run_len(input int unsigned pre_bytes,
                                               input int unsigned decim);
    return fast_run_len(pre_bytes) * decim;
  endfunction

  // Close a byte: newest dibit on top, earlier dibits below it.
  function automatic logic [8:0] close_byte(input logic first,
                                            input logic [1:0] newest,
                                            input logic [5:0] older);
    return {first, newest, older};
  endfunction

endpackage

// File: rtl/rxa_hunt.sv
module rxa_hunt
  import rxa_pkg::*;
#(
  parameter int PRE_BYTES = 7,
  parameter int DECIM     = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dv,
  input  logic       err,
  input  logic [1:0] dibit,
  output rxa_state_e state_o,
  output logic       lock_fast_o,
  output logic       lock_slow_o,
  output logic [1:0] speed_o
);

  localparam int unsigned FAST_RUN = fast_run_len(PRE_BYTES);
  localparam int unsigned SLOW_RUN = slow_run_len(PRE_BYTES, DECIM);
  localparam int CNT_W = $clog2(SLOW_RUN + 2);
  localparam logic [CNT_W-1:0] FAST_CMP = CNT_W'(FAST_RUN);
  localparam logic [CNT_W-1:0] SLOW_CMP = CNT_W'(SLOW_RUN);

  rxa_state_e       st_q, st_d;
  logic [CNT_W-1:0] run_q, run_d;
  logic [1:0]       speed_q, speed_d;
  logic             sfd_seen;

  assign sfd_seen    = (st_q == ST_HUNT) && dv && !err && (dibit == DIBIT_SFD);
  assign lock_fast_o = sfd_seen && (run_q == FAST_CMP);
  assign lock_slow_o = sfd_seen && (run_q == SLOW_CMP);

  always_comb begin
    st_d    = st_q;
    run_d   = run_q;
    speed_d = speed_q;
    unique case (st_q)
      ST_HUNT: begin
        if (!dv) begin
          run_d = '0;
        end else if (err) begin
          st_d = ST_DEAD;
        end else if (dibit == DIBIT_PRE) begin
          if (run_q != '1) run_d = run_q + 1'b1;
        end else if (dibit == DIBIT_SFD) begin
          run_d = '0;
          if (lock_fast_o) begin
            st_d    = ST_DATA;
            speed_d = SPEED_100M;
          end else if (lock_slow_o) begin
            st_d    = ST_DATA;
            speed_d = SPEED_10M;
          end else begin
            st_d = ST_DEAD;
          end
        end else begin
          run_d = '0;
        end
      end
      ST_DATA: begin
        if (!dv)      st_d = ST_HUNT;
        else if (err) st_d = ST_DEAD;
      end
      default: begin
        if (!dv) begin
          st_d  = ST_HUNT;
          run_d = '0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_HUNT;
      run_q   <= '0;
      speed_q <= SPEED_100M;
    end else begin
      st_q    <= st_d;
      run_q   <= run_d;
      speed_q <= speed_d;
    end
  end

  assign state_o = st_q;
  assign speed_o = speed_q;

  // R7: losing data valid always lands in hunt
  assert_dv_low_hunt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dv |=> (st_q == ST_HUNT));

  // R8: an error with data valid always parks the block
  assert_err_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dv && err) |=> (st_q == ST_DEAD));

  // R10: the speed code moves only on a lock
  assert_speed_on_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (speed_q != $past(speed_q)) |-> $past(lock_fast_o || lock_slow_o));

  // R10: only the two detectable rates are ever reported
  assert_speed_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (speed_q == SPEED_10M) || (speed_q == SPEED_100M));

endmodule

// File: rtl/rxa_decim.sv
module rxa_decim #(
  parameter int DECIM = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_slow,
  output logic tick_o
);

  localparam int PH_W = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DECIM - 1);
  localparam logic [PH_W-1:0] PH_AFTER_LOCK = PH_W'(1 % DECIM);

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (lock_slow) begin
      phase_q <= PH_AFTER_LOCK;
    end else if (phase_q == PH_LAST) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign tick_o = (phase_q == '0);

  // R4: no data sample falls on the clock right after a slow lock
  assert_no_tick_after_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_slow |=> !tick_o);

endmodule

// File: rtl/rxa_pack.sv
module rxa_pack
  import rxa_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       take,
  input  logic [1:0] dibit,
  output logic [8:0] byte_o,
  output logic       valid_o
);

  logic [1:0] idx_q;
  logic [5:0] acc_q;
  logic       first_q;
  logic       byte_done;

  assign byte_done = take && (idx_q == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      acc_q   <= '0;
      first_q <= 1'b0;
      byte_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (start) begin
        idx_q   <= '0;
        first_q <= 1'b1;
      end else if (byte_done) begin
        byte_o  <= close_byte(first_q, dibit, acc_q);
        valid_o <= 1'b1;
        first_q <= 1'b0;
        idx_q   <= '0;
      end else if (take) begin
        acc_q <= {dibit, acc_q[5:2]};
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  // R5: a new frame never begins with a byte already on the output
  assert_start_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !valid_o);

endmodule

// File: rtl/rmii_rx_assembler.sv
module rmii_rx_assembler
  import rxa_pkg::*;
#(
  parameter int PRE_BYTES = 7,
  parameter int DECIM     = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rx_dibit,
  input  logic       rx_dv,
  input  logic       rx_err,
  output logic [8:0] rx_byte,
  output logic       rx_byte_valid,
  output logic [1:0] link_speed
);

  localparam int GAP_SLOW = DIBITS_PER_BYTE * DECIM;
  localparam int GAP_W    = $clog2(GAP_SLOW + 1);
  localparam logic [GAP_W-1:0] GAP_MAX  = GAP_W'(GAP_SLOW);
  localparam logic [GAP_W-1:0] GAP_FAST = GAP_W'(DIBITS_PER_BYTE);

  rxa_state_e st;
  logic       lock_fast, lock_slow, frame_start;
  logic       slow_tick, take_dibit;

  rxa_hunt #(.PRE_BYTES(PRE_BYTES), .DECIM(DECIM)) hunt_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .dv          (rx_dv),
    .err         (rx_err),
    .dibit       (rx_dibit),
    .state_o     (st),
    .lock_fast_o (lock_fast),
    .lock_slow_o (lock_slow),
    .speed_o     (link_speed)
  );

  rxa_decim #(.DECIM(DECIM)) decim_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_slow (lock_slow),
    .tick_o    (slow_tick)
  );

  assign frame_start = lock_fast || lock_slow;
  assign take_dibit  = (st == ST_DATA) && rx_dv && !rx_err &&
                       ((link_speed == SPEED_100M) || slow_tick);

  rxa_pack pack_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (frame_start),
    .take    (take_dibit),
    .dibit   (rx_dibit),
    .byte_o  (rx_byte),
    .valid_o (rx_byte_valid)
  );

  // Clocks since the last strobe, kept for the spacing check below.
  logic [GAP_W-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gap_q <= GAP_MAX;
    else if (rx_byte_valid)    gap_q <= GAP_W'(1);
    else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
  end

  // R6: a byte only ever leaves while a frame body is being received
  assert_emit_in_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_byte_valid |-> $past(st == ST_DATA));

  // R11: strobe spacing follows the locked rate
  assert_byte_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_byte_valid |-> (gap_q >= ((link_speed == SPEED_100M) ? GAP_FAST : GAP_MAX)));

endmodule

// File: tb/rmii_rx_assembler_tb_top.sv
module rmii_rx_assembler_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] d = 2'b00;
  logic       dv = 1'b0;
  logic       err = 1'b0;
  logic [8:0] rx_byte;
  logic       rx_byte_valid;
  logic [1:0] link_speed;

  always #2.5 clk = ~clk;

  rmii_rx_assembler dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_dibit      (d),
    .rx_dv         (dv),
    .rx_err        (err),
    .rx_byte       (rx_byte),
    .rx_byte_valid (rx_byte_valid),
    .link_speed    (link_speed)
  );

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: mode 0 hunt, 1 data, 2 parked
  int         m_mode = 0, m_run = 0, m_tick = 0;
  bit         m_fast = 1'b1, m_first = 1'b0;
  logic [1:0] m_q[$];
  logic [8:0] exp_byte = '0;
  logic       exp_valid = 1'b0;
  logic [1:0] exp_speed = 2'd1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_run = 0; exp_valid = 1'b0; exp_byte = '0; exp_speed = 2'd1;
      m_q.delete();
    end else begin
      exp_valid = 1'b0;
      if (m_mode == 0) begin
        if (!dv) m_run = 0;
        else if (err) m_mode = 2;
        else if (d == 2'b01) m_run = m_run + 1;
        else if (d == 2'b11) begin
          if (m_run == 31 || m_run == 310) begin
            m_fast = (m_run == 31);
            exp_speed = m_fast ? 2'd1 : 2'd0;
            m_mode = 1; m_tick = 0; m_first = 1'b1; m_q.delete();
          end else m_mode = 2;
          m_run = 0;
        end else m_run = 0;
      end else if (m_mode == 1) begin
        if (!dv) begin m_mode = 0; m_run = 0; end
        else if (err) m_mode = 2;
        else begin
          m_tick++;
          if (m_fast || (m_tick % 10 == 0)) begin
            if (m_q.size() == 3) begin
              exp_byte = {m_first, d, m_q[2], m_q[1], m_q[0]};
              exp_valid = 1'b1; m_first = 1'b0; m_q.delete();
            end else m_q.push_back(d);
          end
        end
      end else begin
        if (!dv) begin m_mode = 0; m_run = 0; end
      end
    end
  end

  logic [8:0] got[$];
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check_eq(cur_req, "valid", int'(rx_byte_valid), int'(exp_valid));
      check_eq(cur_req, "speed", int'(link_speed), int'(exp_speed));
      if (exp_valid) check_eq(cur_req, "byte", int'(rx_byte), int'(exp_byte));
      if (rx_byte_valid) got.push_back(rx_byte);
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  logic [7:0] tx_q[$];

  task automatic put(input logic [1:0] dd, input int reps, input logic e);
    repeat (reps) begin
      dv = 1'b1; d = dd; err = e;
      @(negedge clk);
    end
  endtask

  // err_at: payload dibit index carrying rx_err, -2 = first preamble dibit, -1 none
  // cut_at: payload dibit index where rx_dv drops, -1 none
  task automatic send_frame(input bit fast, input int npre, input int err_at, input int cut_at);
    int  reps = fast ? 1 : 10;
    int  k = 0;
    bit  stop = 1'b0;
    for (int i = 0; i < npre * 4; i++) put(2'b01, reps, (err_at == -2) && (i == 0));
    for (int i = 0; i < 3; i++) put(2'b01, reps, 1'b0);
    put(2'b11, reps, 1'b0);
    foreach (tx_q[i]) begin
      for (int b = 0; b < 4; b++) begin
        if (k == cut_at) stop = 1'b1;
        if (!stop) put(tx_q[i][2*b +: 2], reps, k == err_at);
        k++;
      end
    end
    dv = 1'b0; d = 2'b00; err = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic expect_bytes(input string req, input int n);
    check_eq(req, "byte count", got.size(), n);
    for (int i = 0; i < n && i < got.size(); i++)
      check_eq(req, "frame byte", int'(got[i]), int'({(i == 0), tx_q[i]}));
    got.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check_eq("R1", "valid after reset", int'(rx_byte_valid), 0);
    check_eq("R1", "speed after reset", int'(link_speed), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R5 R6: 100 Mbit/s frame, asymmetric bytes expose dibit order
    cur_req = "R3";
    tx_q = '{8'hA5, 8'h3C, 8'h01, 8'hFF, 8'h80};
    send_frame(1'b1, 7, -1, -1);
    expect_bytes("R2", 5);
    check_eq("R3", "speed 100M", int'(link_speed), 1);

    // R4 R11: 10 Mbit/s frame
    cur_req = "R4";
    tx_q = '{8'hC3, 8'h7E, 8'h10};
    send_frame(1'b0, 7, -1, -1);
    expect_bytes("R4", 3);
    check_eq("R4", "speed 10M", int'(link_speed), 0);

    // R9: short and long preambles at the fast rate do not lock
    cur_req = "R9";
    tx_q = '{8'h11, 8'h22};
    send_frame(1'b1, 6, -1, -1);
    expect_bytes("R9", 0);
    send_frame(1'b1, 9, -1, -1);
    expect_bytes("R9", 0);
    check_eq("R10", "speed held after no lock", int'(link_speed), 0);

    // R7: data valid drops after ten dibits; two bytes survive
    cur_req = "R7";
    tx_q = '{8'h5A, 8'hE1, 8'h77, 8'h99};
    send_frame(1'b1, 7, -1, 10);
    expect_bytes("R7", 2);
    check_eq("R10", "speed back to 100M", int'(link_speed), 1);

    // R8: error in the fifth payload dibit, rest of frame sent anyway
    cur_req = "R8";
    tx_q = '{8'h4B, 8'h2D, 8'h96, 8'hF0};
    send_frame(1'b1, 7, 4, -1);
    expect_bytes("R8", 1);
    // R8: error on the first preamble dibit
    send_frame(1'b1, 7, -2, -1);
    expect_bytes("R8", 0);

    // R8 R4: error in a slow frame, then a clean slow frame recovers
    cur_req = "R8";
    tx_q = '{8'h0F, 8'hE7};
    send_frame(1'b0, 7, 5, -1);
    expect_bytes("R8", 1);
    cur_req = "R4";
    send_frame(1'b0, 7, -1, -1);
    expect_bytes("R4", 2);

    // R5: back-to-back fast frames each carry their own first flag
    cur_req = "R5";
    tx_q = '{8'hFF, 8'h00, 8'hD5};
    send_frame(1'b1, 7, -1, -1);
    expect_bytes("R5", 3);
    send_frame(1'b1, 7, -1, -1);
    expect_bytes("R5", 3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule